// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block is a bank of 32-bit system control registers on a simple word-access bus. Each register has a fixed reset value. A protection-key register gates a range of the map. Some words are read-only, and one hardware-strap word can only be changed through a set port and a separate clear port. Every write is classified by its target index: stored, set-only, clear-through-alias, key compare, discarded, or out of range. Three error strobes report accesses that break the rules.

The bus has a request strobe, a write enable and a byte address. The two low address bits are dropped, so the word index is the byte address divided by four. A read is combinational: `rdata` shows the stored word at the addressed index while `req` is high and `we` is low. A write takes effect on the rising clock edge where `req` and `we` are both high. The error strobes are combinational and last only for that write cycle.

The block has no sequencing of its own, so its "state machine" is the write classifier. It has six classes:
- NONE: no write.
- KEY: the write goes to the key compare.
- STRAP_SET: the write ORs into the strap word.
- STRAP_CLR: the write clears bits of the strap through the revision address.
- RDONLY: the write is discarded.
- STORE: the write stores the full word.

Each write cycle falls into exactly one class, and the class lasts only that cycle.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the chip-ID words read 0x1234ABCD at 0x150 and 0x88884444 at 0x154. The other reset values are:
  - 0x80000000 at 0x104
  - 0x1E600000 at 0x110
  - 0xC0000000 at 0x114
  - 0x00001903 at 0x160
  - 0x0000007B at 0x180
  - SILREV_VAL at 0x07C
  - STRAP_INIT at 0x070
  - 0 for the key word at 0x000 and for every other in-range word.
- R2: A write to 0x000 sets the key bit to 1 if the data equals UNLOCK_KEY, and to 0 otherwise. A read of 0x000 returns the key bit in bit 0, with bits 31:1 zero. No other word changes.
- R3: While the key bit is 0, a write to index 1 through 64 (byte 0x004 to 0x100) pulses `err_lock`, and the write still takes effect. No lock error is raised when the key bit is 1 or when the index is outside that range.
- R4: A write to 0x070 ORs the data into the strap word. It never clears a strap bit.
- R5: A write to 0x07C leaves the revision word unchanged. It clears every strap bit that is set in the data.
- R6: Writes to the following words are discarded and pulse `err_ro`:
  - scratch words 0x020 to 0x03C
  - 0x04C
  - 0x0A8
  - 0x120 and 0x124
  - 0x150 and 0x154
- R7: A write to any other in-range word stores the full 32-bit data, and a later read returns it.
- R8: An index at or beyond NUM_REGS (byte 0x1C0 and up at the default of 112 words) is out of range. A write there changes nothing and pulses `err_oob` alone. A read there returns 0.
- R9: Address bits 1:0 are ignored, so an access acts on the word at address/4.
- R10: Error strobes are asserted only during a cycle with `req` and `we` both high. A read never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (12) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; 0 when not reading |
| err_lock | output | 1 | Write into the protected range while locked |
| err_ro | output | 1 | Write to a read-only word |
| err_oob | output | 1 | Write beyond the register count |

## Verification
Every readable index, including some past the end, is first swept after reset to pin down the reset table.

Directed writes then compare four cases:
- a locked and an unlocked write to the same protected word, which separates the lock strobe from the store itself;
- a correct and a wrong key, which separates matching from a plain data store;
- set and clear writes with overlapping bit patterns, which tell OR-in and clear-alias apart from a plain store;
- addresses with nonzero low bits, which show that byte offsets fold onto the word.

A long seeded random mix of reads and writes over the full index range, including correct and wrong keys, then checks every strobe and read value against a bench model. This exercises class boundaries and key toggling in orders the directed cases do not reach.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned KEY_IDX      = 0;
    localparam int unsigned SCRATCH_LO   = 8;
    localparam int unsigned SCRATCH_HI   = 15;
    localparam int unsigned RNG_IDX      = 19;
    localparam int unsigned STRAP_IDX    = 28;
    localparam int unsigned SILREV_IDX   = 31;
    localparam int unsigned FREQ_IDX     = 42;
    localparam int unsigned SEG1_IDX     = 65;
    localparam int unsigned SEG4_IDX     = 68;
    localparam int unsigned SEG5_IDX     = 69;
    localparam int unsigned FRC_IDX      = 72;
    localparam int unsigned FRC_EXT_IDX  = 73;
    localparam int unsigned CHIPID0_IDX  = 84;
    localparam int unsigned CHIPID1_IDX  = 85;
    localparam int unsigned UARTCLK_IDX  = 88;
    localparam int unsigned PCIE_IDX     = 96;

    // protected window lies strictly between the key word and segment base 1
    localparam int unsigned LOCK_LO      = KEY_IDX + 1;
    localparam int unsigned LOCK_HI      = SEG1_IDX - 1;

    typedef enum logic [2:0] {
        WC_NONE,
        WC_KEY,
        WC_STRAP_SET,
        WC_STRAP_CLR,
        WC_RDONLY,
        WC_STORE
    } wr_class_e;

    function automatic logic is_rdonly(input int unsigned idx);
        return (idx >= SCRATCH_LO && idx <= SCRATCH_HI) ||
               idx == RNG_IDX || idx == FREQ_IDX ||
               idx == FRC_IDX || idx == FRC_EXT_IDX ||
               idx == CHIPID0_IDX || idx == CHIPID1_IDX;
    endfunction

    function automatic logic [31:0] reset_word(input int unsigned idx,
                                               input logic [31:0] silrev);
        case (idx)
            SEG1_IDX:    return 32'h8000_0000;
            SEG4_IDX:    return 32'h1E60_0000;
            SEG5_IDX:    return 32'hC000_0000;
            CHIPID0_IDX: return 32'h1234_ABCD;
            CHIPID1_IDX: return 32'h8888_4444;
            UARTCLK_IDX: return 32'h0000_1903;
            PCIE_IDX:    return 32'h0000_007B;
            SILREV_IDX:  return silrev;
            default:     return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_REGS = 112,
    parameter int unsigned IDX_W    = 10
) (
    input  logic             req,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic             key_open,
    output logic             key_we,
    output logic             store_en,
    output logic             strap_set,
    output logic             strap_clr,
    output logic             err_lock,
    output logic             err_ro,
    output logic             err_oob
);
    wr_class_e   wclass;
    logic        wr_cyc;
    logic        in_range;
    logic        in_lock_win;
    int unsigned ix;

    assign ix          = int'(idx);
    assign wr_cyc      = req && we;
    assign in_range    = ix < NUM_REGS;
    assign in_lock_win = (ix >= LOCK_LO) && (ix <= LOCK_HI);

    always_comb begin
        wclass = WC_NONE;
        if (wr_cyc && in_range) begin
            if (ix == KEY_IDX)         wclass = WC_KEY;
            else if (ix == STRAP_IDX)  wclass = WC_STRAP_SET;
            else if (ix == SILREV_IDX) wclass = WC_STRAP_CLR;
            else if (is_rdonly(ix))    wclass = WC_RDONLY;
            else                       wclass = WC_STORE;
        end
    end

    always_comb begin
        key_we    = 1'b0;
        store_en  = 1'b0;
        strap_set = 1'b0;
        strap_clr = 1'b0;
        err_ro    = 1'b0;
        unique case (wclass)
            WC_NONE:      ;
            WC_KEY:       key_we    = 1'b1;
            WC_STRAP_SET: strap_set = 1'b1;
            WC_STRAP_CLR: strap_clr = 1'b1;
            WC_RDONLY:    err_ro    = 1'b1;
            WC_STORE:     store_en  = 1'b1;
            default:      ;
        endcase
    end

    assign err_oob  = wr_cyc && !in_range;
    assign err_lock = wr_cyc && in_range && in_lock_win && !key_open;

endmodule

// File: rtl/sysctl_strap.sv
module sysctl_strap #(
    parameter logic [31:0] STRAP_INIT = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_en,
    input  logic        clr_en,
    input  logic [31:0] wdata,
    output logic [31:0] strap_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      strap_q <= STRAP_INIT;
        else if (set_en) strap_q <= strap_q | wdata;
        else if (clr_en) strap_q <= strap_q & ~wdata;
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 112,
    parameter int unsigned IDX_W      = 10,
    parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8,
    parameter logic [31:0] SILREV_VAL = 32'h0401_0303
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic             store_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word,
    output logic             key_open
);
    logic [31:0] word_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g] <= reset_word(g, SILREV_VAL);
            else if (store_en && wr_idx == IDX_W'(g))
                word_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      key_open <= 1'b0;
        else if (key_we) key_open <= (wdata == UNLOCK_KEY);
    end

    always_comb begin
        rd_word = 32'h0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IDX_W'(i)) rd_word = word_q[i];
    end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_REGS   = 112,
    parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8,
    parameter logic [31:0] SILREV_VAL = 32'h0401_0303,
    parameter logic [31:0] STRAP_INIT = 32'hF100_C2E6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err_lock,
    output logic              err_ro,
    output logic              err_oob
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             key_open;
    logic             key_we;
    logic             store_en;
    logic             strap_set;
    logic             strap_clr;
    logic [31:0]      strap_q;
    logic [31:0]      bank_word;

    assign idx = addr[ADDR_W-1:2];

    sysctl_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_decode (
        .req(req), .we(we), .idx(idx), .key_open(key_open),
        .key_we(key_we), .store_en(store_en),
        .strap_set(strap_set), .strap_clr(strap_clr),
        .err_lock(err_lock), .err_ro(err_ro), .err_oob(err_oob)
    );

    sysctl_strap #(.STRAP_INIT(STRAP_INIT)) u_strap (
        .clk(clk), .rst_n(rst_n), .set_en(strap_set), .clr_en(strap_clr),
        .wdata(wdata), .strap_q(strap_q)
    );

    sysctl_bank #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W),
        .UNLOCK_KEY(UNLOCK_KEY), .SILREV_VAL(SILREV_VAL)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .store_en(store_en),
        .wr_idx(idx), .wdata(wdata), .rd_idx(idx),
        .rd_word(bank_word), .key_open(key_open)
    );

    always_comb begin
        rdata = 32'h0;
        if (req && !we && int'(idx) < NUM_REGS) begin
            if (int'(idx) == KEY_IDX)        rdata = {31'h0, key_open};
            else if (int'(idx) == STRAP_IDX) rdata = strap_q;
            else                             rdata = bank_word;
        end
    end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_REGS   = 112,
    parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              err_lock,
    input logic              err_ro,
    input logic              err_oob,
    input logic              key_open,
    input logic [31:0]       strap_q
);
    int unsigned ix;
    assign ix = int'(addr[ADDR_W-1:2]);

    assert_key_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && ix == KEY_IDX) |=> (key_open == ($past(wdata) == UNLOCK_KEY)));

    assert_lock_only_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_lock |-> (!key_open && ix >= LOCK_LO && ix <= LOCK_HI));

    assert_strap_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && ix == STRAP_IDX) |=>
        (((strap_q & $past(strap_q)) == $past(strap_q)) &&
         ((strap_q & $past(wdata)) == $past(wdata))));

    assert_strap_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && ix == SILREV_IDX) |=> ((strap_q & $past(wdata)) == 32'h0));

    assert_strap_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we && (ix == STRAP_IDX || ix == SILREV_IDX)) |=> $stable(strap_q));

    assert_chipid_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && ix == CHIPID0_IDX) |-> rdata == 32'h1234_ABCD);

    assert_oob_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_oob |-> (!err_lock && !err_ro && ix >= NUM_REGS));

    assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && ix >= NUM_REGS) |-> rdata == 32'h0);

    assert_err_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_lock, err_ro, err_oob}) != 0 |-> (req && we));
endmodule

bind sysctl_regs sysctl_regs_chk #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err_lock(err_lock), .err_ro(err_ro),
    .err_oob(err_oob), .key_open(key_open), .strap_q(strap_q)
);

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
    localparam int unsigned CLK_P   = 10;
    localparam int unsigned NREG    = 112;
    localparam logic [31:0] KEY     = 32'h1688_A8A8;
    localparam logic [31:0] REV     = 32'h0401_0303;
    localparam logic [31:0] STRAP0  = 32'hF100_C2E6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err_lock, err_ro, err_oob;

    int unsigned total = 0;
    int unsigned bad = 0;

    logic [31:0] m_mem [NREG];
    logic        m_key;
    logic [31:0] m_strap;

    always #(CLK_P/2) clk = ~clk;

    sysctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err_lock(err_lock),
        .err_ro(err_ro), .err_oob(err_oob)
    );

    function automatic logic [31:0] rst_val(input int unsigned i);
        case (i)
            65: return 32'h8000_0000;
            68: return 32'h1E60_0000;
            69: return 32'hC000_0000;
            84: return 32'h1234_ABCD;
            85: return 32'h8888_4444;
            88: return 32'h0000_1903;
            96: return 32'h0000_007B;
            31: return REV;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic ro_word(input int unsigned i);
        return (i >= 8 && i <= 15) || i == 19 || i == 42 || i == 72 ||
               i == 73 || i == 84 || i == 85;
    endfunction

    function automatic logic [31:0] exp_read(input int unsigned i);
        if (i >= NREG) return 32'h0;
        if (i == 0)    return {31'h0, m_key};
        if (i == 28)   return m_strap;
        return m_mem[i];
    endfunction

    function automatic logic [2:0] exp_err(input logic w, input int unsigned i);
        logic oob;
        oob = i >= NREG;
        if (!w) return 3'b000;
        return {!oob && !m_key && i >= 1 && i <= 64, !oob && ro_word(i), oob};
    endfunction

    function automatic string wtag(input int unsigned i);
        if (i >= NREG)   return "R8";
        if (ro_word(i))  return "R6";
        if (i == 0)      return "R2";
        if (i == 28)     return "R4";
        if (i == 31)     return "R5";
        if (i <= 64)     return "R3";
        return "R7";
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic w, input logic [11:0] a, input logic [31:0] d,
                         input string tag);
        int unsigned i;
        i = int'(a[11:2]);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #1;
        check32(w ? wtag(i) : "R10", {29'h0, err_lock, err_ro, err_oob},
                {29'h0, exp_err(w, i)});
        if (!w) check32(tag, rdata, exp_read(i));
        @(posedge clk);
        if (w && i < NREG) begin
            if (i == 0)           m_key = (d == KEY);
            else if (i == 28)     m_strap = m_strap | d;
            else if (i == 31)     m_strap = m_strap & ~d;
            else if (!ro_word(i)) m_mem[i] = d;
        end
    endtask

    function automatic logic [11:0] wa(input int unsigned i);
        return 12'(i << 2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) m_mem[i] = rst_val(i);
        m_key = 1'b0;
        m_strap = STRAP0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset sweep including out-of-range words (R8)
        for (int i = 0; i < 128; i++)
            do_op(1'b0, wa(i), 32'h0, i < NREG ? "R1" : "R8");

        // R3: locked write lands and flags, unlocked write does not flag
        do_op(1'b1, wa(40), 32'hDEAD_0001, "R3");
        do_op(1'b0, wa(40), 32'h0, "R3");
        do_op(1'b1, wa(0), KEY, "R2");
        do_op(1'b0, wa(0), 32'h0, "R2");
        do_op(1'b1, wa(40), 32'hBEEF_0002, "R3");
        do_op(1'b0, wa(40), 32'h0, "R3");
        do_op(1'b1, wa(0), KEY ^ 32'h1, "R2");
        do_op(1'b0, wa(0), 32'h0, "R2");
        do_op(1'b0, wa(40), 32'h0, "R2");
        // R4/R5: set and clear the strap, revision unchanged
        do_op(1'b1, wa(28), 32'h0000_0F0F, "R4");
        do_op(1'b0, wa(28), 32'h0, "R4");
        do_op(1'b1, wa(28), 32'h0, "R4");
        do_op(1'b0, wa(28), 32'h0, "R4");
        do_op(1'b1, wa(31), 32'hF000_00FF, "R5");
        do_op(1'b0, wa(28), 32'h0, "R5");
        do_op(1'b0, wa(31), 32'h0, "R5");
        // R6: chip ID is not writable
        do_op(1'b1, wa(84), 32'h0, "R6");
        do_op(1'b0, wa(84), 32'h0, "R6");
        do_op(1'b1, wa(12), 32'h5555_AAAA, "R6");
        do_op(1'b0, wa(12), 32'h0, "R6");
        // R7: plain store above the protected window
        do_op(1'b1, wa(100), 32'hCAFE_F00D, "R7");
        do_op(1'b0, wa(100), 32'h0, "R7");
        // R8: out-of-range write then read
        do_op(1'b1, wa(120), 32'hFFFF_FFFF, "R8");
        do_op(1'b0, wa(120), 32'h0, "R8");
        // R9: low address bits ignored
        do_op(1'b1, wa(70) | 12'h3, 32'h0BAD_C0DE, "R9");
        do_op(1'b0, wa(70) | 12'h1, 32'h0, "R9");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned i;
            logic [31:0] d;
            logic w;
            i = $urandom % 128;
            if (($urandom % 8) == 0) i = 0;
            if (($urandom % 10) == 0) i = (($urandom % 2) == 0) ? 28 : 31;
            d = $urandom;
            if (i == 0 && ($urandom % 2) == 0) d = KEY;
            w = ($urandom % 2) == 1;
            do_op(w, wa(i) | 12'($urandom % 4), d, "R7");
        end

        @(negedge clk);
        req = 1'b0; we = 1'b0;
        #1;
        check32("R10", {29'h0, err_lock, err_ro, err_oob}, 32'h0);
        check32("R10", rdata, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule